// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external 8K x 8 asynchronous static RAM. A user request carries a 13-bit address, a write flag and an 8-bit write byte. The controller runs the memory's strobes through a fixed sequence and answers with a one-cycle done pulse. A read returns its byte on a held data output. Every strobe leaving the block is registered, so the pins change only on clock edges.

The memory is selected by a pair of enables of opposite polarity: one active low and one active high. The controller always drives the two together. Read access, write pulse and bus turnaround each last a whole number of clock cycles. Each count is derived at elaboration time from a required time in picoseconds and the clock period: the ceiling of the ratio, with a floor of one. The shared data bus is split into an output byte, an input byte and a drive enable. The drive enable is sequenced so that the controller never drives the bus while the memory's outputs may still be on.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, and on the first cycles after it, the memory is deselected (`mem_cs1_n`=1, `mem_cs2`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_done`=0 and `req_ready`=1.
- R2: The two enables always change on the same edge and hold opposite levels. They are asserted for the whole of a transaction and deasserted whenever the controller is idle.
- R3: A read asserts the enables and drives `mem_oe_n` low from the edge that accepts the request, for exactly AA_CYC cycles (ceil(T_AA_PS/CLK_PS), at least 1). `mem_we_n` stays high throughout.
- R4: A read captures the memory byte on the last access cycle. `rsp_rdata` then holds that byte until the next read completes, and writes leave it unchanged.
- R5: A write asserts the enables with `mem_we_n` and `mem_oe_n` high for TURN_CYC cycles, then drives `mem_we_n` low for WP_CYC cycles. It then keeps the enables asserted with `mem_we_n` high for one more cycle.
- R6: `mem_dq_oe` is high only while `mem_oe_n` is high and the memory is selected. It rises on the edge where `mem_we_n` falls and drops on the edge where `mem_we_n` rises.
- R7: `req_ready` is low from the accepting edge until the done cycle has passed. A request presented while `req_ready` is low is ignored and never reaches the memory.
- R8: `mem_addr` and `mem_dq_out` stay stable for as long as the memory is selected.
- R9: `rsp_done` is high for exactly one cycle, in the cycle after the enables deassert.
- R10: A request presented in the first cycle in which `req_ready` is high again is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller can accept a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 13 | Memory address |
| mem_cs1_n | output | 1 | Memory enable, active low |
| mem_cs2 | output | 1 | Memory enable, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Byte the controller drives onto the bus |
| mem_dq_oe | output | 1 | Controller bus-drive enable |
| mem_dq_in | input | 8 | Byte sampled from the bus |

## Verification
The assertions assume that `mem_dq_in` settles within the access window, because the memory model answers at once. They also assume that the request inputs may change in any cycle, since R7 requires busy-time requests to be dropped. The stimulus changes request inputs only on falling edges. It drives busy-time requests to an untouched address and then reads that address back to show it is unchanged. The bus model flags any cycle in which both the controller and the memory would drive the bus.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_RD    = 3'd1,
    SEQ_TURN  = 3'd2,
    SEQ_WPUL  = 3'd3,
    SEQ_WHOLD = 3'd4,
    SEQ_DONE  = 3'd5
  } seq_st_e;

  // cycles needed to cover t_ps at a clock period of clk_ps, never below one
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
`timescale 1ns/1ps
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/sram_cyc_timer.sv
`timescale 1ns/1ps
module sram_cyc_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_data_regs.sv
`timescale 1ns/1ps
module sram_data_regs #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_in;
  end
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W    = 2,
  parameter int AA_CYC   = 3,
  parameter int WP_CYC   = 3,
  parameter int TURN_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             req_ready,
  output logic             rsp_done,
  output logic             cs1_n,
  output logic             cs2,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);
  seq_st_e st_q, st_d;
  logic    sel_d, rd_d, wr_d, done_d, ready_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: if (req_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (req_write) begin
          st_d    = SEQ_TURN;
          tmr_val = CNT_W'(TURN_CYC - 1);
        end else begin
          st_d    = SEQ_RD;
          tmr_val = CNT_W'(AA_CYC - 1);
        end
      end
      SEQ_RD: if (tmr_expired) begin
        capture = 1'b1;
        st_d    = SEQ_DONE;
      end
      SEQ_TURN: if (tmr_expired) begin
        st_d     = SEQ_WPUL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC - 1);
      end
      SEQ_WPUL:  if (tmr_expired) st_d = SEQ_WHOLD;
      SEQ_WHOLD: st_d = SEQ_DONE;
      SEQ_DONE:  st_d = SEQ_IDLE;
      default:   st_d = SEQ_IDLE;
    endcase
    sel_d   = (st_d == SEQ_RD) || (st_d == SEQ_TURN) ||
              (st_d == SEQ_WPUL) || (st_d == SEQ_WHOLD);
    rd_d    = (st_d == SEQ_RD);
    wr_d    = (st_d == SEQ_WPUL);
    done_d  = (st_d == SEQ_DONE);
    ready_d = (st_d == SEQ_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      cs1_n     <= 1'b1;
      cs2       <= 1'b0;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      rsp_done  <= 1'b0;
      req_ready <= 1'b1;
    end else begin
      st_q      <= st_d;
      cs1_n     <= !sel_d;
      cs2       <= sel_d;
      oe_n      <= !rd_d;
      we_n      <= !wr_d;
      dq_oe     <= wr_d;
      rsp_done  <= done_d;
      req_ready <= ready_d;
    end
  end

  // R6: controller drives the bus only with memory outputs disabled
  assert_drive_oe_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_n && !cs1_n && cs2));
  // R6: drive released on the edge that ends the write strobe
  assert_release_with_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> $rose(we_n));
  // R5: a write strobe always has the memory selected and data driven
  assert_we_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs1_n && cs2 && dq_oe));
  // R2: enables always carry opposite levels
  assert_enables_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs2 == !cs1_n);
  // R9: done lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R7: never ready while the memory is selected
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs1_n |-> !req_ready);
  // R3: output enable never overlaps a write strobe
  assert_oe_we_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int CLK_PS    = 5000,
  parameter int T_AA_PS   = 15000,
  parameter int T_WP_PS   = 13000,
  parameter int T_TURN_PS = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int AA_CYC   = cyc_of(T_AA_PS, CLK_PS);
  localparam int WP_CYC   = cyc_of(T_WP_PS, CLK_PS);
  localparam int TURN_CYC = cyc_of(T_TURN_PS, CLK_PS);
  localparam int MAX_AW   = (AA_CYC > WP_CYC) ? AA_CYC : WP_CYC;
  localparam int MAX_CYC  = (MAX_AW > TURN_CYC) ? MAX_AW : TURN_CYC;
  localparam int CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             rst_q;
  logic             tmr_load, tmr_expired, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q)
  );

  sram_cyc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_q), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  sram_seq_fsm #(
    .CNT_W(CNT_W), .AA_CYC(AA_CYC), .WP_CYC(WP_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_q), .req_valid(req_valid), .req_write(req_write),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .accept(accept), .capture(capture), .req_ready(req_ready),
    .rsp_done(rsp_done), .cs1_n(mem_cs1_n), .cs2(mem_cs2),
    .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe)
  );

  sram_data_regs #(.AW(AW), .DW(DW)) u_dat (
    .clk(clk), .rst_n(rst_q), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .rdata_q(rsp_rdata)
  );

  // R8: address and write byte held while selected
  assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
  // R4: read byte only changes on the edge that ends a read access
  assert_rdata_held_R4: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(rsp_rdata) |-> ($rose(mem_oe_n) && rsp_done));
endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;
  localparam int CLK_PS = 5000;
  localparam int AA   = (15000 + CLK_PS - 1) / CLK_PS;
  localparam int WP   = (13000 + CLK_PS - 1) / CLK_PS;
  localparam int TURN = (10000 + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [12:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [12:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mem_arr [0:8191];
  logic [7:0] ref_arr [0:8191];
  logic [7:0] last_rd = 8'h00;

  always #2.5 clk = ~clk;

  sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // behavioural memory: drives only when selected, reading, outputs enabled
  wire mem_sel = (mem_cs1_n === 1'b0) && (mem_cs2 === 1'b1);
  assign mem_dq_in = (mem_sel && mem_we_n && !mem_oe_n) ? mem_arr[mem_addr] : 8'h00;
  always @(posedge mem_we_n) if (mem_sel) mem_arr[mem_addr] = mem_dq_out;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    check({tag, " R2 cs1_n idle"}, int'(mem_cs1_n), 1);
    check({tag, " R2 cs2 idle"}, int'(mem_cs2), 0);
    check({tag, " R3 oe_n idle"}, int'(mem_oe_n), 1);
    check({tag, " R5 we_n idle"}, int'(mem_we_n), 1);
    check({tag, " R6 dq_oe idle"}, int'(mem_dq_oe), 0);
    check({tag, " R9 done idle"}, int'(rsp_done), 0);
    check({tag, " R7 ready idle"}, int'(req_ready), 1);
  endtask

  // starts at a negedge with the controller ready; returns at the negedge it is ready again
  task automatic txn(input bit wr, input logic [12:0] a, input logic [7:0] d,
                     input bit poke, input bit b2b);
    int total;
    bit sel_e, oe_e, we_e, done_e, rdy_e;
    if (b2b) check("R10 ready before back-to-back", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    total = wr ? (TURN + WP + 3) : (AA + 2);
    if (wr) ref_arr[a] = d;
    for (int t = 1; t <= total; t++) begin
      if (wr) begin
        sel_e = (t <= TURN + WP + 1);
        we_e  = (t > TURN) && (t <= TURN + WP);
        oe_e  = 1'b0;
        done_e = (t == TURN + WP + 2);
      end else begin
        sel_e = (t <= AA);
        we_e  = 1'b0;
        oe_e  = (t <= AA);
        done_e = (t == AA + 1);
      end
      rdy_e = (t == total);
      check("R2 cs1_n", int'(mem_cs1_n), int'(!sel_e));
      check("R2 cs2", int'(mem_cs2), int'(sel_e));
      check("R3 oe_n", int'(mem_oe_n), int'(!oe_e));
      check("R5 we_n", int'(mem_we_n), int'(!we_e));
      check("R6 dq_oe", int'(mem_dq_oe), int'(we_e));
      check("R9 done", int'(rsp_done), int'(done_e));
      check("R7 ready", int'(req_ready), int'(rdy_e));
      check("R6 no bus contention", int'(mem_dq_oe && mem_sel && !mem_oe_n), 0);
      if (sel_e) check("R8 address", int'(mem_addr), int'(a));
      if (sel_e && wr) check("R8 write byte", int'(mem_dq_out), int'(d));
      if (!wr && t > AA) check("R4 read byte", int'(rsp_rdata), int'(ref_arr[a]));
      if (wr) check("R4 read byte kept", int'(rsp_rdata), int'(last_rd));
      if (poke && t == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0ABC; req_wdata = 8'hEE;
      end
      if (poke && t == 3) req_valid = 1'b0;
      if (t < total) @(negedge clk);
    end
    if (!wr) last_rd = ref_arr[a];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) begin
      mem_arr[i] = 8'(i) ^ 8'h5A;
      ref_arr[i] = 8'(i) ^ 8'h5A;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 after reset");
    check("R1 rdata reset", int'(rsp_rdata), 0);

    txn(1'b1, 13'h0123, 8'hA5, 1'b0, 1'b0);
    @(negedge clk);
    check_idle("R2 gap");
    txn(1'b0, 13'h0123, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    txn(1'b0, 13'h0456, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    // busy-time request must be dropped (R7)
    txn(1'b1, 13'h0200, 8'h3C, 1'b1, 1'b0);
    @(negedge clk);
    check_idle("R7 after dropped request");
    txn(1'b0, 13'h0ABC, 8'h00, 1'b0, 1'b0);
    // back-to-back at address boundaries (R10)
    txn(1'b1, 13'h0000, 8'h11, 1'b0, 1'b1);
    txn(1'b1, 13'h1FFF, 8'hFE, 1'b0, 1'b1);
    txn(1'b0, 13'h1FFF, 8'h00, 1'b0, 1'b1);
    txn(1'b0, 13'h0000, 8'h00, 1'b0, 1'b1);
    txn(1'b0, 13'h0200, 8'h00, 1'b0, 1'b1);
    for (int k = 0; k < 24; k++) begin
      logic [12:0] a;
      a = 13'((k * 1237 + 91) % 8192);
      txn(k[0], a, 8'((k * 29) ^ 8'hC3), 1'b0, 1'b1);
      if (k % 3 == 0) begin
        @(negedge clk);
        check_idle("R2 loop gap");
      end
    end
    @(negedge clk);
    check_idle("R2 final");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule